// File: doc/BRIEF.md
# Serial Break Character Detector

This block sits on the receive side of an asynchronous serial port. It runs after the oversampling and bit-alignment logic. It takes one already-decided line value per bit time, qualified by a strobe, and decides whether the line has been held low long enough to count as a break character rather than an ordinary frame. A run is measured only from a start bit, which is a low sample that follows a high sample. Any high sample ends the run.

The required run length depends on two controls. One selects the 9-bit character format. The other adds one extra data bit time for LIN-style breaks. The required run is the start bit, then the data bits, then a low sample in the stop slot: 10, 11 or 12 consecutive zeros in total. When a run reaches that length, the block emits a single-cycle pulse and sets a sticky flag that stays set until a clear input removes it. After a detection the block does not count again until the line has returned high.

Top module: `brkdet_top`

## Requirements
- R1: With `nine_bit` = 0 and `lin_ext` = 0, a break is reported on the 10th consecutive low sample counted from the start bit.
- R2: With `nine_bit` = 1 and `lin_ext` = 0, a break is reported on the 11th consecutive low sample counted from the start bit.
- R3: With `nine_bit` = 0 and `lin_ext` = 1, a break is reported on the 11th consecutive low sample counted from the start bit.
- R4: With `nine_bit` = 1 and `lin_ext` = 1, a break is reported on the 12th consecutive low sample counted from the start bit.
- R5: A low run one sample shorter than the selected length is not reported. A high sample (`rx_bit` = 1) at any point clears the run count.
- R6: A run starts only on a low sample whose previous qualified sample was high. After reset, no high sample has been seen, so low samples arriving before the first high sample are never counted.
- R7: `brk_pulse` is high for exactly one clock cycle. That cycle is the one after the clock edge that accepted the completing low sample.
- R8: After a detection, further low samples produce no new pulse. Detection re-arms only after a high sample followed by a new start bit.
- R9: `brk_flag` goes high together with `brk_pulse` and stays high until `flag_clear` is sampled high on a clock edge; it is low from the following cycle. If a detection and `flag_clear` fall on the same edge, the flag stays set.
- R10: When `bit_valid` is low, `rx_bit` is ignored: no pulse, no change to the flag, and no effect on the run in progress.
- R11: While `rst_n` is low, and in the first cycle after it is released, `brk_pulse` and `brk_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bit | input | 1 | Receive line value for the current bit time (1 = idle/mark) |
| bit_valid | input | 1 | One-cycle strobe qualifying `rx_bit` |
| nine_bit | input | 1 | 1 selects the 9-bit character format |
| lin_ext | input | 1 | 1 adds one bit time to the break length |
| flag_clear | input | 1 | Clears the sticky break flag |
| brk_pulse | output | 1 | Single-cycle break detection event |
| brk_flag | output | 1 | Sticky break indication |

## Verification
A corrupted run counter first shows at the ports as a `brk_pulse` one strobe too early or too late, or missing altogether. It is visible within the next 12 qualified samples. A broken start-edge or re-arm state shows as a second pulse during a continued low line, or as a pulse after reset without any prior high sample. Either appears within one break length. A faulty flag register is caught at the first cycle after a clear, or at the first cycle after a detection in which the flag fails to match the pulse.

// File: rtl/brkdet_pkg.sv
package brkdet_pkg;

  // Zeros needed for a break: start bit + data bits + stop slot.
  function automatic int unsigned brk_run_len(input int unsigned data_bits,
                                              input logic nine,
                                              input logic lin);
    int unsigned len;
    len = 1 + data_bits + 1;
    if (nine) len = len + 1;
    if (lin)  len = len + 1;
    return len;
  endfunction

  // Longest run any mode can ask for.
  function automatic int unsigned brk_max_len(input int unsigned data_bits);
    return data_bits + 4;
  endfunction

endpackage

// File: rtl/brkdet_thresh.sv
module brkdet_thresh
  import brkdet_pkg::*;
#(
  parameter int unsigned DATA_BITS = 8,
  parameter int unsigned CW        = 4
) (
  input  logic          nine_bit,
  input  logic          lin_ext,
  output logic [CW-1:0] thr
);

  localparam int unsigned N_MODES = 4;

  logic [CW-1:0] table_q [N_MODES];

  // One entry per mode combination, index = {nine, lin}.
  for (genvar m = 0; m < N_MODES; m++) begin : g_mode
    localparam logic NINE = m[1];
    localparam logic LIN  = m[0];
    assign table_q[m] = CW'(brk_run_len(DATA_BITS, NINE, LIN));
  end

  always_comb begin
    thr = table_q[{nine_bit, lin_ext}];
  end

endmodule

// File: rtl/brkdet_run.sv
module brkdet_run #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_valid,
  input  logic          rx_bit,
  input  logic [CW-1:0] thr,
  output logic [CW-1:0] run_cnt,
  output logic          line_high,
  output logic          start_evt,
  output logic          cont_evt,
  output logic          one_evt,
  output logic          hit_evt
);

  logic [CW:0] run_inc;
  logic        zero_evt;
  logic        in_run;

  assign zero_evt  = bit_valid & ~rx_bit;
  assign one_evt   = bit_valid &  rx_bit;
  assign in_run    = (run_cnt != '0);
  assign start_evt = zero_evt & ~in_run & line_high;
  assign cont_evt  = zero_evt &  in_run;
  assign run_inc   = {1'b0, run_cnt} + 1'b1;
  assign hit_evt   = (start_evt | cont_evt) & (run_inc >= {1'b0, thr});

  // Last qualified line value; reset low so a mark must be seen first.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         line_high <= 1'b0;
    else if (bit_valid) line_high <= rx_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     run_cnt <= '0;
    else if (one_evt || hit_evt)    run_cnt <= '0;
    else if (start_evt || cont_evt) run_cnt <= run_inc[CW-1:0];
  end

endmodule

// File: rtl/brkdet_flag.sv
module brkdet_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_evt,
  input  logic flag_clear,
  output logic brk_pulse,
  output logic brk_flag
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) brk_pulse <= 1'b0;
    else        brk_pulse <= hit_evt;
  end

  // Set has priority over clear so no detection is lost.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          brk_flag <= 1'b0;
    else if (hit_evt)    brk_flag <= 1'b1;
    else if (flag_clear) brk_flag <= 1'b0;
  end

endmodule

// File: rtl/brkdet_top.sv
module brkdet_top
  import brkdet_pkg::*;
#(
  parameter int unsigned DATA_BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_bit,
  input  logic bit_valid,
  input  logic nine_bit,
  input  logic lin_ext,
  input  logic flag_clear,
  output logic brk_pulse,
  output logic brk_flag
);

  localparam int unsigned MAX_LEN = brk_max_len(DATA_BITS);
  localparam int unsigned CW      = $clog2(MAX_LEN + 1);

  logic [CW-1:0] thr;
  logic [CW-1:0] run_cnt;
  logic          line_high;
  logic          start_evt;
  logic          cont_evt;
  logic          one_evt;
  logic          hit_evt;

  brkdet_thresh #(.DATA_BITS(DATA_BITS), .CW(CW)) u_thresh (
    .nine_bit (nine_bit),
    .lin_ext  (lin_ext),
    .thr      (thr)
  );

  brkdet_run #(.CW(CW)) u_run (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_valid (bit_valid),
    .rx_bit    (rx_bit),
    .thr       (thr),
    .run_cnt   (run_cnt),
    .line_high (line_high),
    .start_evt (start_evt),
    .cont_evt  (cont_evt),
    .one_evt   (one_evt),
    .hit_evt   (hit_evt)
  );

  brkdet_flag u_flag (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit_evt    (hit_evt),
    .flag_clear (flag_clear),
    .brk_pulse  (brk_pulse),
    .brk_flag   (brk_flag)
  );

endmodule

// File: rtl/brkdet_chk.sv
module brkdet_chk #(
  parameter int unsigned CW      = 4,
  parameter int unsigned MAX_LEN = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_bit,
  input logic          bit_valid,
  input logic          flag_clear,
  input logic          brk_pulse,
  input logic          brk_flag,
  input logic [CW-1:0] thr,
  input logic [CW-1:0] run_cnt,
  input logic          line_high,
  input logic          hit_evt
);

  // R7: the pulse never lasts two cycles.
  p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    brk_pulse |=> !brk_pulse);

  // R9: pulse and flag go up together.
  p_flag_with_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    brk_pulse |-> brk_flag);

  // R9: the flag holds without a clear.
  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_flag && !flag_clear) |=> brk_flag);

  // R9: a clear without a detection drops the flag.
  p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clear && !hit_evt) |=> !brk_flag);

  // R10: no strobe, no run change and no pulse.
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |=> ($stable(run_cnt) && !brk_pulse));

  // R8: after a detection the counter is idle and the line is marked low.
  p_rearm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt |=> (run_cnt == '0 && !line_high));

  // R5: a high sample empties the run.
  p_one_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && rx_bit) |=> (run_cnt == '0));

  // R1-style bound: the run never exceeds the longest length.
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt < CW'(MAX_LEN));

  // R5: a detection requires a run one short of the selected length.
  p_hit_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt |-> (run_cnt + 1'b1 >= thr));

endmodule

bind brkdet_top brkdet_chk #(.CW(CW), .MAX_LEN(MAX_LEN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_bit     (rx_bit),
  .bit_valid  (bit_valid),
  .flag_clear (flag_clear),
  .brk_pulse  (brk_pulse),
  .brk_flag   (brk_flag),
  .thr        (thr),
  .run_cnt    (run_cnt),
  .line_high  (line_high),
  .hit_evt    (hit_evt)
);

// File: tb/brkdet_top_tb.sv
module brkdet_top_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_bit = 1'b1;
  logic bit_valid = 1'b0;
  logic nine_bit = 1'b0;
  logic lin_ext = 1'b0;
  logic flag_clear = 1'b0;
  logic brk_pulse;
  logic brk_flag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Bench model state.
  int  m_cnt = 0;
  bit  m_high = 0;
  bit  m_flag = 0;

  always #10 clk = ~clk;

  brkdet_top u_dut (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .bit_valid(bit_valid),
    .nine_bit(nine_bit), .lin_ext(lin_ext), .flag_clear(flag_clear),
    .brk_pulse(brk_pulse), .brk_flag(brk_flag)
  );

  function automatic int exp_len(input logic nine, input logic lin);
    case ({nine, lin})
      2'b00:   return 10;
      2'b01:   return 11;
      2'b10:   return 11;
      default: return 12;
    endcase
  endfunction

  function automatic string len_tag(input logic nine, input logic lin);
    case ({nine, lin})
      2'b00:   return "R1";
      2'b10:   return "R2";
      2'b01:   return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Apply one qualified sample; returns the observed pulse.
  task automatic send_bit(input logic b, input logic clr, output logic p);
    bit exp_hit;
    @(negedge clk);
    rx_bit = b; bit_valid = 1'b1; flag_clear = clr;
    @(negedge clk);
    bit_valid = 1'b0; flag_clear = 1'b0;
    p = brk_pulse;
    exp_hit = 0;
    if (b) begin
      m_cnt = 0; m_high = 1;
    end else begin
      if (m_cnt > 0) m_cnt++;
      else if (m_high) m_cnt = 1;
      if (m_cnt > 0 && m_cnt >= exp_len(nine_bit, lin_ext)) begin
        exp_hit = 1; m_cnt = 0;
      end
      m_high = 0;
    end
    if (exp_hit) m_flag = 1;
    else if (clr) m_flag = 0;
    check("R7", "pulse after strobe", p, exp_hit);
    check("R9", "flag after strobe", brk_flag, m_flag);
  endtask

  // Cycles without a strobe; the line toggles but must be ignored.
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_bit = 1'($urandom);
      @(negedge clk);
      check("R10", "pulse while unqualified", brk_pulse, 0);
      check("R10", "flag while unqualified", brk_flag, m_flag);
    end
  endtask

  task automatic clear_flag();
    @(negedge clk);
    flag_clear = 1'b1;
    @(negedge clk);
    flag_clear = 1'b0;
    m_flag = 0;
    check("R9", "flag after clear", brk_flag, 0);
  endtask

  // Sends n zeros; returns the 1-based index of the first pulse, or 0.
  task automatic zeros(input int n, output int at);
    logic p;
    at = 0;
    for (int i = 1; i <= n; i++) begin
      send_bit(1'b0, 1'b0, p);
      if (p && at == 0) at = i;
    end
  endtask

  initial begin
    logic p;
    int at;
    void'($urandom(32'h5eed_b4e7));

    #1;
    check("R11", "pulse in reset", brk_pulse, 0);
    check("R11", "flag in reset", brk_flag, 0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11", "pulse after reset", brk_pulse, 0);
    check("R11", "flag after reset", brk_flag, 0);

    // R6: low line from reset never counts.
    zeros(14, at);
    check("R6", "no start without prior mark", at, 0);

    // Directed: every mode combination.
    for (int m = 0; m < 4; m++) begin
      nine_bit = m[1]; lin_ext = m[0];
      send_bit(1'b1, 1'b0, p);
      zeros(exp_len(nine_bit, lin_ext) - 1, at);
      check("R5", "one short of length", at, 0);
      send_bit(1'b1, 1'b0, p);
      zeros(exp_len(nine_bit, lin_ext), at);
      check(len_tag(nine_bit, lin_ext), "break position", at,
            exp_len(nine_bit, lin_ext));
      idle(2);
      zeros(5, at);
      check("R8", "no repeat while low", at, 0);
      clear_flag();
      send_bit(1'b1, 1'b0, p);
      zeros(exp_len(nine_bit, lin_ext), at);
      check("R8", "rearmed after mark", at, exp_len(nine_bit, lin_ext));
      clear_flag();
    end

    // R9: a detection and a clear on the same edge leave the flag set.
    nine_bit = 0; lin_ext = 0;
    send_bit(1'b1, 1'b0, p);
    zeros(9, at);
    send_bit(1'b0, 1'b1, p);
    check("R9", "set beats clear", brk_flag, 1);
    clear_flag();

    // R5: a mark midway restarts the count.
    send_bit(1'b1, 1'b0, p);
    zeros(6, at);
    send_bit(1'b1, 1'b0, p);
    zeros(9, at);
    check("R5", "mark restarts run", at, 0);
    send_bit(1'b1, 1'b0, p);

    // Random: mode per burst, long low runs mixed with marks and gaps.
    for (int k = 0; k < 300; k++) begin
      nine_bit = 1'($urandom); lin_ext = 1'($urandom);
      for (int j = 0; j < 30; j++) begin
        send_bit(($urandom % 8) == 0, ($urandom % 16) == 0, p);
        if (($urandom % 4) == 0) idle(1);
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule